// File: doc/BRIEF.md
# I2C Control Register Slave with Status Readback

This block is a bus target that lets a host microcontroller program a bank of adjustment and control registers over a two-wire serial bus and read back a single byte of live status. The bus lines are sampled with the fast system clock. Each line passes through a synchronizer and a glitch filter. The filtered lines feed a byte engine that detects start and stop conditions, matches the device address, runs a subaddress counter and drives SDA through an open-drain enable.

Write transfers name a subaddress and then send data bytes. The subaddress steps forward after each byte, so the host can refill the whole bank in one burst. Read transfers need no subaddress: the slave returns one status byte that is frozen when the transfer starts. The register contents appear as parallel outputs. Two control bits act as single-cycle strobes rather than stored values.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The first byte after a start holds the 7-bit device address (default 0x46, so 0x8C writes and 0x8D reads) with the direction in bit 0. On a match the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA and ignores the rest of the transfer until the next start.
- R2: In a write, the second byte loads the subaddress counter and the third byte is stored in the register it selects. Every byte of a write addressed to this device is acknowledged.
- R3: Each further data byte in the same write goes to the next subaddress. After subaddress 17 the counter returns to 0.
- R4: Subaddresses 0..15 hold adjustment register i on adj_o[8*i+7:8*i]. Subaddress 16 is an 8-bit control register on ctl_a_o. At subaddress 17, bits 6:2 are stored on ctl_b_o[4:0] and bit 7 is dropped. Writes to subaddresses 18..255 are acknowledged and discarded, and from there the counter steps by one modulo 256. No register changes outside a completed write byte.
- R5: After reset, every adjustment register reads 0x80, ctl_a_o and ctl_b_o are 0, both strobes are low and SDA is released.
- R6: In a read, the slave sends one status byte MSB first, with bits {h_lock, v_lock, xray, h_pol, v_pol, hv_det, v_det, vext_det} from bit 7 down to bit 0. The byte is captured at the SCL fall that ends the address acknowledge, so later input changes do not alter it. The slave then releases SDA, samples the host's ACK or NACK and goes idle.
- R7: A stop condition at any point returns the slave to idle and releases SDA. A partly received byte is discarded.
- R8: A write to subaddress 17 with bit 0 set gives exactly one clock cycle of refresh_o. With bit 1 set it gives exactly one clock cycle of xray_clr_o.
- R9: The filter ignores any pulse on SCL or SDA shorter than FILT_LEN clock cycles (12 cycles, 60 ns at 200 MHz). Valid bus edges reach the byte engine within FILT_LEN+2 cycles, which is ample for a 400 kHz bus.
- R10: A repeated start with no stop before it ends the current transfer and treats the next byte as an address byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 200 MHz nominal |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain enable) |
| h_lock_i | input | 1 | Horizontal lock status |
| v_lock_i | input | 1 | Vertical lock status |
| xray_i | input | 1 | X-ray protection tripped |
| h_pol_i | input | 1 | Detected horizontal sync polarity |
| v_pol_i | input | 1 | Detected vertical sync polarity |
| hv_det_i | input | 1 | Combined H/V sync detected |
| v_det_i | input | 1 | Vertical sync detected |
| vext_det_i | input | 1 | Separate vertical sync detected |
| adj_o | output | NUM_ADJ*8 | Adjustment registers, register i in bits 8*i+7:8*i |
| ctl_a_o | output | 8 | Control register at subaddress 16 |
| ctl_b_o | output | 5 | Stored control bits 6:2 of subaddress 17 |
| refresh_o | output | 1 | One-cycle detection-refresh strobe |
| xray_clr_o | output | 1 | One-cycle X-ray latch clear strobe |

## Verification
The write path is exercised in several ways:
- single-byte writes;
- bursts that cross the wrap from 17 to 0;
- bursts that start out of range and roll past 255;
- random bursts checked against a model of the bank.

Together these separate a counter that never advances from one that wraps at the wrong point or writes where it should discard. Transfers with a wrong address, a stop inside a byte, and a repeated start check that only completed, addressed bytes reach the bank.

Status reads use random patterns. In some of them the inputs are inverted while the byte is being shifted out, which shows whether the value is frozen at capture or read live. Pulses shorter than the filter length are injected on SCL while it is low and on SDA while SCL is high. A failing filter would then show up as an extra bit or as a false start or stop.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } link_st_t;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int   FILT_LEN = 12,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // The output follows the synchronized input only after it has differed
  // for FILT_LEN consecutive cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      run_q  <= '0;
      filt_o <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        filt_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import i2c_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int         LAST_SUB = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] status_i,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_sub,
  output logic [7:0] wr_data,
  output logic       start_det,
  output logic       stop_det,
  output link_st_t   st
);
  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall;
  logic [3:0] bit_q;
  logic [1:0] byte_q;
  logic       rd_q;
  logic       ack_drv_q;
  logic [7:0] rx_sh, tx_sh, sub_q;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign sda_oe    = ack_drv_q | ((st == ST_TX) & ~tx_sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      st        <= ST_IDLE;
      bit_q     <= '0;
      byte_q    <= '0;
      rd_q      <= 1'b0;
      ack_drv_q <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      sub_q     <= '0;
      wr_en     <= 1'b0;
      wr_sub    <= '0;
      wr_data   <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (stop_det) begin
        st        <= ST_IDLE;
        ack_drv_q <= 1'b0;
      end else if (start_det) begin
        st        <= ST_RX;
        bit_q     <= '0;
        byte_q    <= '0;
        rd_q      <= 1'b0;
        ack_drv_q <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[6:0], sda_f};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (byte_q == 2'd0) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rd_q      <= rx_sh[0];
                  ack_drv_q <= 1'b1;
                  st        <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                ack_drv_q <= 1'b1;
                st        <= ST_ACK;
                if (byte_q == 2'd1) begin
                  sub_q <= rx_sh;
                end else begin
                  wr_en   <= 1'b1;
                  wr_sub  <= sub_q;
                  wr_data <= rx_sh;
                  sub_q   <= (sub_q == 8'(LAST_SUB)) ? 8'd0 : sub_q + 8'd1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_q     <= '0;
              ack_drv_q <= 1'b0;
              if (rd_q && byte_q == 2'd0) begin
                tx_sh <= status_i;
                st    <= ST_TX;
              end else begin
                st <= ST_RX;
                if (byte_q != 2'd2) byte_q <= byte_q + 2'd1;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_q == 4'd8) st <= ST_RACK;
              else tx_sh <= {tx_sh[6:0], 1'b1};
            end
          end
          ST_RACK: begin
            if (scl_rise) st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank #(
  parameter int         NUM_ADJ = 16,
  parameter logic [7:0] ADJ_RST = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_sub,
  input  logic [7:0]           wr_data,
  output logic [NUM_ADJ*8-1:0] adj_o,
  output logic [7:0]           ctl_a_o,
  output logic [4:0]           ctl_b_o,
  output logic                 refresh_o,
  output logic                 xray_clr_o
);
  localparam logic [7:0] SUB_A = 8'(NUM_ADJ);
  localparam logic [7:0] SUB_B = 8'(NUM_ADJ + 1);

  logic [7:0] adj_q [NUM_ADJ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ADJ; i++) adj_q[i] <= ADJ_RST;
      ctl_a_o    <= '0;
      ctl_b_o    <= '0;
      refresh_o  <= 1'b0;
      xray_clr_o <= 1'b0;
    end else begin
      refresh_o  <= 1'b0;
      xray_clr_o <= 1'b0;
      if (wr_en) begin
        for (int i = 0; i < NUM_ADJ; i++)
          if (wr_sub == 8'(i)) adj_q[i] <= wr_data;
        if (wr_sub == SUB_A) ctl_a_o <= wr_data;
        if (wr_sub == SUB_B) begin
          ctl_b_o    <= wr_data[6:2];
          refresh_o  <= wr_data[0];
          xray_clr_o <= wr_data[1];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ADJ; g++) begin : g_adj
    assign adj_o[8*g +: 8] = adj_q[g];
  end
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
  import i2c_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int         NUM_ADJ  = 16,
  parameter int         FILT_LEN = 12,
  parameter logic [7:0] ADJ_RST  = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 h_lock_i,
  input  logic                 v_lock_i,
  input  logic                 xray_i,
  input  logic                 h_pol_i,
  input  logic                 v_pol_i,
  input  logic                 hv_det_i,
  input  logic                 v_det_i,
  input  logic                 vext_det_i,
  output logic [NUM_ADJ*8-1:0] adj_o,
  output logic [7:0]           ctl_a_o,
  output logic [4:0]           ctl_b_o,
  output logic                 refresh_o,
  output logic                 xray_clr_o
);
  localparam int LAST_SUB = NUM_ADJ + 1;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       wr_en, start_det, stop_det;
  logic [7:0] wr_sub, wr_data, status_b;
  link_st_t   link_st;

  assign raw_lines = {sda_i, scl_i};
  assign scl_f     = filt_lines[0];
  assign sda_f     = filt_lines[1];
  assign status_b  = {h_lock_i, v_lock_i, xray_i, h_pol_i,
                      v_pol_i, hv_det_i, v_det_i, vext_det_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .filt_o(filt_lines[g])
    );
  end

  i2c_link #(.DEV_ADDR(DEV_ADDR), .LAST_SUB(LAST_SUB)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .status_i(status_b), .sda_oe(sda_oe_o), .wr_en(wr_en),
    .wr_sub(wr_sub), .wr_data(wr_data), .start_det(start_det),
    .stop_det(stop_det), .st(link_st)
  );

  ctrl_regbank #(.NUM_ADJ(NUM_ADJ), .ADJ_RST(ADJ_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sub(wr_sub),
    .wr_data(wr_data), .adj_o(adj_o), .ctl_a_o(ctl_a_o),
    .ctl_b_o(ctl_b_o), .refresh_o(refresh_o), .xray_clr_o(xray_clr_o)
  );
endmodule

// File: rtl/i2c_ctrl_slave_chk.sv
module i2c_ctrl_slave_chk
  import i2c_ctrl_pkg::*;
#(
  parameter int ADJ_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_f,
  input logic             stop_det,
  input logic             wr_en,
  input link_st_t         st,
  input logic [ADJ_W-1:0] adj,
  input logic             refresh,
  input logic             xclr
);
  // R7: an idle slave never holds SDA
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R7: a stop always leads to idle with SDA released
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == ST_IDLE));

  // R4: the bank only changes after a write strobe from the byte engine
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(adj));

  // R8: strobes last one cycle
  p_refresh_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !refresh);
  p_xclr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xclr |=> !xclr);

  // R2: the slave starts driving SDA only while SCL is low
  p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk #(.ADJ_W(NUM_ADJ*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_f(scl_f),
  .stop_det(stop_det), .wr_en(wr_en), .st(link_st), .adj(adj_o),
  .refresh(refresh_o), .xclr(xray_clr_o)
);

// File: tb/test_i2c_ctrl_slave.sv
`timescale 1ns/100ps
module test_i2c_ctrl_slave;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] stat = 8'h00;
  logic sda_oe;
  logic [127:0] adj;
  logic [7:0] ctl_a;
  logic [4:0] ctl_b;
  logic refresh, xclr;
  wire sda_bus = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_ctrl_slave i_i2c_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .h_lock_i(stat[7]), .v_lock_i(stat[6]), .xray_i(stat[5]), .h_pol_i(stat[4]),
    .v_pol_i(stat[3]), .hv_det_i(stat[2]), .v_det_i(stat[1]), .vext_det_i(stat[0]),
    .adj_o(adj), .ctl_a_o(ctl_a), .ctl_b_o(ctl_b), .refresh_o(refresh),
    .xray_clr_o(xclr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_adj [16];
  logic [7:0] m_ca;
  logic [4:0] m_cb;
  int exp_ref = 0, exp_xc = 0;
  int ref_hi = 0, ref_ev = 0, xc_hi = 0, xc_ev = 0;
  logic ref_p = 0, xc_p = 0;
  logic [7:0] wbuf [32];

  always @(negedge clk) begin
    if (refresh) ref_hi++;
    if (refresh && !ref_p) ref_ev++;
    if (xclr) xc_hi++;
    if (xclr && !xc_p) xc_ev++;
    ref_p = refresh;
    xc_p  = xclr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] next_sub(input logic [7:0] s);
    return (s == 8'd17) ? 8'd0 : s + 8'd1;
  endfunction

  task automatic model_write(input logic [7:0] s, input logic [7:0] d);
    if (s < 8'd16) m_adj[s[3:0]] = d;
    else if (s == 8'd16) m_ca = d;
    else if (s == 8'd17) begin
      m_cb = d[6:2];
      if (d[0]) exp_ref++;
      if (d[1]) exp_xc++;
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 16; i++)
      chk(adj[8*i +: 8] == m_adj[i], req, $sformatf("adj[%0d]", i),
          32'(adj[8*i +: 8]), 32'(m_adj[i]));
    chk(ctl_a == m_ca, req, "ctl_a", 32'(ctl_a), 32'(m_ca));
    chk(ctl_b == m_cb, req, "ctl_b", 32'(ctl_b), 32'(m_cb));
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(2);
  endtask

  // g=1: short SCL pulse in the low phase; g=2: short SDA flip in the high phase
  task automatic send_bit(input logic b, input int g);
    m_sda = b;
    if (g == 1) begin
      repeat (4) @(negedge clk); m_scl = 1'b1;
      repeat (4) @(negedge clk); m_scl = 1'b0;
      repeat (Q - 8) @(negedge clk);
    end else qw(1);
    m_scl = 1'b1;
    if (g == 2) begin
      repeat (6) @(negedge clk); m_sda = ~b;
      repeat (4) @(negedge clk); m_sda = b;
      repeat (2 * Q - 10) @(negedge clk);
    end else qw(2);
    m_scl = 1'b0; qw(1);
  endtask

  task automatic send_byte(input logic [7:0] b, input int g, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 3) ? g : 0);
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1);
    ack = ~sda_bus;
    qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic recv_byte(input logic host_ack, input bit flip,
                           output logic [7:0] b, output logic bus_at_ack);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(1); m_scl = 1'b1; qw(1);
      b = {b[6:0], sda_bus};
      if (flip && i == 2) stat = ~stat;
      qw(1); m_scl = 1'b0; qw(1);
    end
    m_sda = ~host_ack; qw(1); m_scl = 1'b1; qw(1);
    bus_at_ack = sda_bus;
    qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic do_write(input logic [7:0] sub, input int n, input string req);
    logic a;
    logic [7:0] s;
    i2c_start();
    send_byte(8'h8C, 0, a); chk(a, "R1", "addr ack", 32'(a), 1);
    send_byte(sub, 0, a);   chk(a, "R2", "sub ack", 32'(a), 1);
    s = sub;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], 0, a);
      chk(a, req, "data ack", 32'(a), 1);
      model_write(s, wbuf[k]);
      s = next_sub(s);
    end
    i2c_stop();
    check_bank(req);
  endtask

  task automatic do_read(input logic [7:0] v, input bit flip, input logic hack);
    logic a, bat;
    logic [7:0] got;
    stat = v;
    i2c_start();
    send_byte(8'h8D, 0, a); chk(a, "R1", "read addr ack", 32'(a), 1);
    recv_byte(hack, flip, got, bat);
    chk(got == v, "R6", "status byte", 32'(got), 32'(v));
    chk(bat == ~hack, "R6", "bus at host ack", 32'(bat), 32'(~hack));
    i2c_stop();
    chk(sda_oe == 1'b0, "R6", "released after read", 32'(sda_oe), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) m_adj[i] = 8'h80;
    m_ca = 8'h00; m_cb = 5'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);

    // R5 reset state
    check_bank("R5");
    chk(!sda_oe && !refresh && !xclr, "R5", "strobes/oe after reset",
        32'({sda_oe, refresh, xclr}), 0);

    // R2 single write
    wbuf[0] = 8'h3C; do_write(8'd5, 1, "R2");

    // R3 burst across the wrap 16,17,0,1 and R8 strobes
    wbuf[0] = 8'hA5; wbuf[1] = 8'h7F; wbuf[2] = 8'h11; wbuf[3] = 8'h22;
    do_write(8'd16, 4, "R3");
    wbuf[0] = 8'h01; do_write(8'd17, 1, "R8");
    wbuf[0] = 8'h02; do_write(8'd17, 1, "R8");

    // R4 out-of-range writes discarded, counter rolls past 255
    wbuf[0] = 8'h99; wbuf[1] = 8'h98; wbuf[2] = 8'h55; wbuf[3] = 8'h66;
    do_write(8'hFE, 4, "R4");
    wbuf[0] = 8'hEE; do_write(8'd32, 1, "R4");

    // R1 wrong address: no ack, bank untouched
    i2c_start();
    send_byte(8'h8E, 0, a); chk(!a, "R1", "foreign addr nack", 32'(a), 0);
    send_byte(8'h02, 0, a); chk(!a, "R1", "foreign sub nack", 32'(a), 0);
    send_byte(8'h12, 0, a); chk(!a, "R1", "foreign data nack", 32'(a), 0);
    i2c_stop();
    check_bank("R1");

    // R7 stop inside a data byte
    i2c_start();
    send_byte(8'h8C, 0, a); send_byte(8'd7, 0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
    i2c_stop();
    chk(sda_oe == 1'b0, "R7", "released after stop", 32'(sda_oe), 0);
    check_bank("R7");

    // R10 repeated start
    i2c_start();
    send_byte(8'h8C, 0, a); send_byte(8'd3, 0, a); send_byte(8'h4D, 0, a);
    model_write(8'd3, 8'h4D);
    i2c_start();
    send_byte(8'h8C, 0, a); chk(a, "R10", "addr after rep start", 32'(a), 1);
    send_byte(8'd9, 0, a); send_byte(8'hB2, 0, a);
    model_write(8'd9, 8'hB2);
    i2c_stop();
    check_bank("R10");

    // R9 glitches on SCL (low phase) and SDA (high phase)
    i2c_start();
    send_byte(8'h8C, 1, a); chk(a, "R9", "addr ack with scl glitch", 32'(a), 1);
    send_byte(8'd12, 2, a);
    send_byte(8'hC3, 1, a); model_write(8'd12, 8'hC3);
    send_byte(8'h5A, 2, a); model_write(8'd13, 8'h5A);
    i2c_stop();
    check_bank("R9");

    // R6 reads, fixed and with inputs changing mid-byte
    do_read(8'hA6, 0, 1'b0);
    do_read(8'h59, 1, 1'b1);

    // Random writes and reads
    for (int t = 0; t < 8; t++) begin
      int n;
      logic [7:0] s;
      n = 1 + int'($urandom_range(5));
      s = 8'($urandom_range(19));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(s, n, "R3");
      do_read(8'($urandom), t[0], t[1]);
    end

    repeat (20) @(negedge clk);
    chk(ref_hi == exp_ref && ref_ev == exp_ref, "R8", "refresh pulses",
        32'(ref_hi), 32'(exp_ref));
    chk(xc_hi == exp_xc && xc_ev == exp_xc, "R8", "xray clear pulses",
        32'(xc_hi), 32'(exp_xc));

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule